// File: doc/BRIEF.md
# Microprocessor Bus Cycle Sequencer

This block produces the memory bus handshakes of an 8-bit microprocessor. It takes one bus cycle request at a time and plays out the strobe sequence for that cycle. A request names the cycle kind (opcode fetch, memory read or memory write), an address and, for writes, a data byte. The block drives the address bus, the write data with its output enable, and the active-low strobes `mreq_n`, `rd_n`, `wr_n`, `m1_n` and `rfsh_n`. It returns the sampled read byte with a one-clock response pulse.

The block runs on a clock at twice the T-state rate. Each clock is one half T-state, so edges that fall half a T-state apart can be placed exactly. An opcode fetch lasts four T-states (8 clocks). Its last two T-states carry a 7-bit refresh address taken from an internal counter. Memory read and write cycles last three T-states (6 clocks). Requests use a valid/ready handshake. While a cycle is in flight, `cmd_ready` is low, so a waiting request is held back; holding `cmd_valid` high is the only back-pressure. `cmd_ready` also rises in the final half T-state, so cycles can run back to back with no idle clock. The response side cannot be stalled: `rsp_valid` is a one-clock pulse and the consumer must take it in that clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted, every strobe is high, `bus_oe` is low, `bus_addr` is zero, `rsp_valid` is low and `cmd_ready` is high. The refresh counter restarts at 0.
- R2: A request is taken at a rising clock edge when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high when idle and in the final phase of a cycle. Phase 0 of the taken cycle is the next clock. `cmd_kind` encoding: 00 fetch, 01 read, 10 write, 11 treated as read.
- R3: During fetch phases 0 to 3, `bus_addr` equals the request address. `m1_n` is low in those phases and high in all other clocks.
- R4: During a fetch, `mreq_n` and `rd_n` are low in phases 1 to 3. They are high in phase 0 and from phase 4 on.
- R5: A fetch returns the `bus_din` value present in phase 3, which is captured at the edge that begins T3.
- R6: During fetch phases 4 to 7, `bus_addr` is the refresh count in bits 6:0, with zeros above. `rfsh_n` is low in those phases, and `mreq_n` is low in phases 5 and 6 only.
- R7: The refresh counter steps by one when a fetch ends and wraps from 127 to 0. Reads and writes leave it unchanged.
- R8: A read lasts 6 phases, with `bus_addr` held for all of them. `mreq_n` and `rd_n` are low in phases 1 to 4. The returned byte is the `bus_din` value present in phase 4.
- R9: A write lasts 6 phases. `bus_addr`, `bus_dout` and `bus_oe` = 1 are held for all of them. `mreq_n` is low in phases 1 to 4, `wr_n` is low in phases 3 and 4, and `rd_n` stays high.
- R10: `rsp_valid` is high for exactly the final phase of each cycle: phase 7 of a fetch, phase 5 of a read or write. `rsp_data` changes only on fetch and read captures; writes leave it unchanged.
- R11: When no cycle is in flight, all strobes are high, `bus_oe` is low and `bus_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request can be taken this clock |
| cmd_kind | input | 2 | Cycle kind (00 fetch, 01 read, 10 write, 11 read) |
| cmd_addr | input | 16 | Cycle address |
| cmd_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock end-of-cycle pulse |
| rsp_data | output | 8 | Last captured read byte |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Write data to the bus |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 8 | Read data from the bus |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | Fetch marker, active low |
| rfsh_n | output | 1 | Refresh marker, active low |

## Verification
The outputs of phase k fall in the (k+1)-th clock after the edge that takes the request. `rsp_valid` is therefore due in the 8th clock after a fetch is taken and in the 6th clock after a read or write is taken. Captured read data becomes visible one clock after the capture phase and stays until the next capture. A behavioural model in the bench advances on each rising edge from the same request stream, and every output is compared with it at the following falling edge. A late or early strobe, address or capture therefore shows up in the exact clock it occurs. The bench drives `bus_din` as a function of `bus_addr`, so capturing in the wrong phase returns a byte derived from the refresh address instead of the request address.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_RSVD  = 2'b11
  } kind_t;

  localparam int PH_W = 3;
  localparam logic [PH_W-1:0] FETCH_LAST = 3'd7;
  localparam logic [PH_W-1:0] DATA_LAST  = 3'd5;
endpackage

// File: rtl/bcs_refresh_ctr.sv
module bcs_refresh_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // R7: counter wraps to zero after its top value
  assert_refresh_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (count == {W{1'b1}})) |=> (count == '0));
endmodule

// File: rtl/bcs_phase_seq.sv
module bcs_phase_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              busy,
  output kind_t             kind,
  output logic [PH_W-1:0]   phase,
  output logic              last,
  output logic              fetch_end,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  kind_t           kind_in;
  logic            take;
  logic [PH_W-1:0] last_ph;

  always_comb begin
    case (kind_t'(cmd_kind))
      K_FETCH: kind_in = K_FETCH;
      K_WRITE: kind_in = K_WRITE;
      default: kind_in = K_READ;
    endcase
  end

  assign last_ph   = (kind == K_FETCH) ? FETCH_LAST : DATA_LAST;
  assign last      = busy && (phase == last_ph);
  assign cmd_ready = !busy || last;
  assign take      = cmd_valid && cmd_ready;
  assign fetch_end = last && (kind == K_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= '0;
      kind    <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      phase   <= '0;
      kind    <= kind_in;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end else if (last) begin
      busy    <= 1'b0;
    end else if (busy) begin
      phase   <= phase + 1'b1;
    end
  end

  // R2: a taken request starts at phase 0 on the next clock
  assert_start_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && (phase == '0)));
  // R8: data cycles never run past their sixth phase
  assert_data_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (kind != K_FETCH)) |-> (phase <= DATA_LAST));
endmodule

// File: rtl/bcs_strobe_dec.sv
module bcs_strobe_dec
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RFSH_W = 7
) (
  input  logic              busy,
  input  kind_t             kind,
  input  logic [PH_W-1:0]   phase,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [RFSH_W-1:0] rcount,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              rfsh_n,
  output logic              capture
);
  localparam int PAD_W = ADDR_W - RFSH_W;
  logic [ADDR_W-1:0] rfsh_addr;
  logic              mid;   // phases 1..4: the body of every access

  assign rfsh_addr = {{PAD_W{1'b0}}, rcount};
  assign mid       = (phase >= 3'd1) && (phase <= 3'd4);

  always_comb begin
    bus_addr = '0;
    bus_dout = '0;
    bus_oe   = 1'b0;
    mreq_n   = 1'b1;
    rd_n     = 1'b1;
    wr_n     = 1'b1;
    m1_n     = 1'b1;
    rfsh_n   = 1'b1;
    capture  = 1'b0;
    if (busy) begin
      case (kind)
        K_FETCH: begin
          if (phase < 3'd4) begin
            bus_addr = addr_q;
            m1_n     = 1'b0;
            if (phase != 3'd0) begin
              mreq_n = 1'b0;
              rd_n   = 1'b0;
            end
            capture = (phase == 3'd3);
          end else begin
            bus_addr = rfsh_addr;
            rfsh_n   = 1'b0;
            if ((phase == 3'd5) || (phase == 3'd6)) mreq_n = 1'b0;
          end
        end
        K_WRITE: begin
          bus_addr = addr_q;
          bus_dout = wdata_q;
          bus_oe   = 1'b1;
          if (mid) mreq_n = 1'b0;
          if ((phase == 3'd3) || (phase == 3'd4)) wr_n = 1'b0;
        end
        default: begin
          bus_addr = addr_q;
          if (mid) begin
            mreq_n = 1'b0;
            rd_n   = 1'b0;
          end
          capture = (phase == 3'd4);
        end
      endcase
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RFSH_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              rfsh_n
);
  logic              busy, last, fetch_end, capture;
  kind_t             kind;
  logic [PH_W-1:0]   phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [RFSH_W-1:0] rcount;

  bcs_phase_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .busy(busy), .kind(kind), .phase(phase), .last(last),
    .fetch_end(fetch_end), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  bcs_refresh_ctr #(.W(RFSH_W)) u_rfsh (
    .clk(clk), .rst_n(rst_n), .step(fetch_end), .count(rcount)
  );

  bcs_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RFSH_W(RFSH_W)) u_dec (
    .busy(busy), .kind(kind), .phase(phase), .addr_q(addr_q),
    .wdata_q(wdata_q), .rcount(rcount), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .capture(capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_data <= '0;
    else if (capture) rsp_data <= bus_din;
  end

  assign rsp_valid = last;

  // R9: read and write strobes never overlap
  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R9: write strobe only while data is driven
  assert_wr_has_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe);
  // R6: fetch marker and refresh marker are disjoint
  assert_m1_rfsh_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!m1_n && !rfsh_n));
  // R7: end of a refresh phase advances the counter by one
  assert_refresh_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_n) |-> (rcount == $past(rcount) + 1'b1));
  // R10: response is a single-clock pulse
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'b00;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic [7:0]  bus_din;
  logic        mreq_n, rd_n, wr_n, m1_n, rfsh_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign bus_din = mem_byte(bus_addr);

  bus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n)
  );

  // Reference model: kind 0 fetch, 1 read, 2 write; -1 idle
  int          m_kind = -1;
  int          m_ph = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wd = '0;
  logic [7:0]  m_rc = '0;
  logic [7:0]  m_rdata = '0;

  function automatic int m_len();
    return (m_kind == 0) ? 8 : 6;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kind = -1; m_ph = 0; m_rc = '0; m_rdata = '0;
    end else begin
      bit fin;
      bit rdy;
      fin = (m_kind >= 0) && (m_ph == m_len() - 1);
      rdy = (m_kind < 0) || fin;
      if (m_kind == 0 && m_ph == 3) m_rdata = mem_byte(m_addr);
      if (m_kind == 1 && m_ph == 4) m_rdata = mem_byte(m_addr);
      if (fin && m_kind == 0) m_rc = (m_rc + 8'd1) & 8'h7F;
      if (cmd_valid && rdy) begin
        m_kind = (cmd_kind == 2'b00) ? 0 : (cmd_kind == 2'b10) ? 2 : 1;
        m_ph = 0; m_addr = cmd_addr; m_wd = cmd_wdata;
      end else if (fin) begin
        m_kind = -1; m_ph = 0;
      end else if (m_kind >= 0) begin
        m_ph++;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R1", "strobes in reset", {11'd0, mreq_n, rd_n, wr_n, m1_n, rfsh_n}, 16'h001F);
      chk("R1", "oe/valid/ready in reset", {13'd0, bus_oe, rsp_valid, cmd_ready}, 16'h0001);
      chk("R1", "addr in reset", bus_addr, 16'h0000);
    end else begin
      logic [15:0] e_addr;
      logic [7:0]  e_dout;
      logic e_oe, e_mreq, e_rd, e_wr, e_m1, e_rf, e_rv, e_ready;
      string t;
      e_addr = '0; e_dout = '0; e_oe = 0;
      e_mreq = 1; e_rd = 1; e_wr = 1; e_m1 = 1; e_rf = 1;
      e_rv = (m_kind >= 0) && (m_ph == m_len() - 1);
      e_ready = (m_kind < 0) || e_rv;
      t = "R11";
      if (m_kind == 0 && m_ph < 4) begin
        t = "R3"; e_addr = m_addr; e_m1 = 0;
        if (m_ph >= 1) begin e_mreq = 0; e_rd = 0; end
      end else if (m_kind == 0) begin
        t = "R6"; e_addr = {9'd0, m_rc[6:0]}; e_rf = 0;
        if (m_ph == 5 || m_ph == 6) e_mreq = 0;
        chk("R7", "refresh count on bus", {9'd0, bus_addr[6:0]}, {9'd0, m_rc[6:0]});
      end else if (m_kind == 1) begin
        t = "R8"; e_addr = m_addr;
        if (m_ph >= 1 && m_ph <= 4) begin e_mreq = 0; e_rd = 0; end
      end else if (m_kind == 2) begin
        t = "R9"; e_addr = m_addr; e_dout = m_wd; e_oe = 1;
        if (m_ph >= 1 && m_ph <= 4) e_mreq = 0;
        if (m_ph == 3 || m_ph == 4) e_wr = 0;
      end
      chk(t, "bus_addr", bus_addr, e_addr);
      chk((m_kind == 0) ? "R4" : t, "mreq_n/rd_n", {14'd0, mreq_n, rd_n}, {14'd0, e_mreq, e_rd});
      chk("R9", "wr_n/oe/dout", {7'd0, wr_n, bus_oe, bus_dout}, {7'd0, e_wr, e_oe, e_dout});
      chk("R3", "m1_n", {15'd0, m1_n}, {15'd0, e_m1});
      chk("R6", "rfsh_n", {15'd0, rfsh_n}, {15'd0, e_rf});
      chk("R2", "cmd_ready", {15'd0, cmd_ready}, {15'd0, e_ready});
      chk("R10", "rsp_valid", {15'd0, rsp_valid}, {15'd0, e_rv});
      chk("R5", "rsp_data (R8 reads, R10 writes keep)", {8'd0, rsp_data}, {8'd0, m_rdata});
    end
  end

  // Issue one request; returns at the falling edge after it was taken
  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_wdata = d;
    forever begin
      if (cmd_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R3 R4 R5 R6: single fetch
    issue(2'b00, 16'h1234, 8'h00); idle(10);
    // R8: single read
    issue(2'b01, 16'hBEEF, 8'h00); idle(8);
    // R9 R10: write keeps rsp_data
    issue(2'b10, 16'h4000, 8'h3C); idle(8);
    // R2: reserved kind acts as read
    issue(2'b11, 16'h0F0F, 8'h77); idle(8);
    // R2: back-to-back mix with request held while busy
    issue(2'b00, 16'h8000, 8'h00);
    issue(2'b10, 16'h8001, 8'hA1);
    issue(2'b01, 16'h8002, 8'h00);
    issue(2'b00, 16'h8003, 8'h00);
    idle(12);
    // R7: many fetches to wrap the 7-bit counter
    for (int i = 0; i < 130; i++) begin
      issue(2'b00, 16'(i * 37), 8'h00);
      if (i % 16 == 0) idle(3);
    end
    idle(12);
    issue(2'b01, 16'hFFFF, 8'h00);
    issue(2'b10, 16'h0000, 8'hFF);
    idle(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule